// File: doc/BRIEF.md
# Wide Quadrant Address Generator

This block forms a 96-bit linear virtual address for memory accesses and control transfers. The upper 48 bits are a quadrant number taken from one of a small set of high-part sources. The lower 48 bits come from a 64-bit base register, optionally offset by a sign-extended 34-bit index that is scaled by 1, 2, 4 or 8. Ordinary loads and stores, including stack-pointer based ones, use the global high register as their quadrant. Branches and link-register based accesses use the program-counter high register. Wide operations take the quadrant from the second register of a register pair.

A linear sub-mode applies to memory operations. In that mode the quadrant is not concatenated. It is shifted up by 48 and added to the full zero-extended 64-bit base and the scaled index, so the carry can cross quadrant boundaries. A permission input decides whether user-mode code may issue wide operations. A disallowed request raises a privilege fault instead of producing an address. One request is accepted per cycle, and the result appears one cycle later on a registered output.

Top module: `qagu_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid`, `out_addr`, `out_fault` and `out_pch_load` are all zero.
- R2: `out_valid` equals the value `in_valid` had one cycle earlier. When `in_valid` is low, `out_addr`, `out_fault` and `out_pch_load` keep their previous values.
- R3: Operation code 0 (plain memory access, also used for stack-pointer accesses), and the reserved codes 6 and 7, produce `{gbh, (base[47:0] + scaled index) mod 2^48}` when linear mode is off.
- R4: Operation code 1 (wide memory access) uses `in_pair_hi[47:0]` as the quadrant and the same low-half sum as R3.
- R5: Code 2 (PC-relative branch) produces `{pch, (base[47:0] + scaled index) mod 2^48}`. Code 3 (register branch) produces `{pch, base[47:0]}` and ignores the index. Neither code sets `out_pch_load`, and linear mode has no effect on either.
- R6: Code 4 (long jump) produces `{pair_hi[47:0], base[47:0]}`, ignores the index and linear mode, and sets `out_pch_load` to 1.
- R7: Code 5 (link-register based memory access) uses `in_pch` as the quadrant and the same low-half sum as R3.
- R8: The scaled index is `in_idx`, treated as a signed 34-bit value and shifted left by `in_scale` (0 to 3).
- R9: When `in_lin` is 1 and the code is a memory access (0, 1, 5, 6 or 7), the address is `(quadrant << 48) + zero-extended base + scaled index`, taken modulo 2^96.
- R10: A code 1 or code 4 request with `in_user`=1 and `in_wide_ok`=0 gives `out_fault`=1, `out_addr`=0 and `out_pch_load`=0. In every other case `out_fault` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 3 | Operation code (see R3 to R7) |
| in_lin | input | 1 | Linear sub-mode for memory operations |
| in_user | input | 1 | Request issued in user mode |
| in_wide_ok | input | 1 | User mode may issue wide operations |
| in_base | input | 64 | Base register value or PC |
| in_pair_hi | input | 64 | Second register of a register pair |
| in_idx | input | 34 | Signed index or displacement |
| in_scale | input | 2 | Left shift applied to the index |
| in_gbh | input | 48 | Global high register |
| in_pch | input | 48 | Program-counter high register |
| out_valid | output | 1 | Result valid |
| out_addr | output | 96 | Linear virtual address |
| out_fault | output | 2 | Fault code: 0 none, 1 privilege |
| out_pch_load | output | 1 | Target quadrant must be loaded into PC-high |

## Verification
The bench builds the block with its default widths: a 48-bit quadrant, a 48-bit low half, a 64-bit base and a 34-bit index with a 2-bit scale. At these widths all four scale factors and the sign extension of negative indices can be exercised. An all-ones quadrant combined with a large base reaches wrap-around at 2^96 in linear mode, and a base near 2^48 shows that the concatenated mode drops the carry. Random requests over every operation code and every permission combination are mixed with these directed edges.

// File: rtl/qagu_pkg.sv
package qagu_pkg;
  typedef enum logic [2:0] {
    OP_MEM   = 3'd0,
    OP_WIDE  = 3'd1,
    OP_BRREL = 3'd2,
    OP_BRREG = 3'd3,
    OP_JLONG = 3'd4,
    OP_LRREL = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } agu_op_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PRIV = 2'd1
  } agu_flt_e;

  typedef enum logic [1:0] {
    HS_GBH  = 2'd0,
    HS_PCH  = 2'd1,
    HS_PAIR = 2'd2
  } hsrc_e;
endpackage

// File: rtl/qagu_decode.sv
module qagu_decode
  import qagu_pkg::*;
(
  input  agu_op_e op,
  input  logic    user,
  input  logic    wide_ok,
  output hsrc_e   hsrc,
  output logic    use_idx,
  output logic    mem_op,
  output logic    pch_load,
  output logic    priv_fault
);
  logic wide_op;

  always_comb begin
    hsrc     = HS_GBH;
    use_idx  = 1'b1;
    mem_op   = 1'b1;
    pch_load = 1'b0;
    wide_op  = 1'b0;
    case (op)
      OP_WIDE: begin
        hsrc    = HS_PAIR;
        wide_op = 1'b1;
      end
      OP_BRREL: begin
        hsrc   = HS_PCH;
        mem_op = 1'b0;
      end
      OP_BRREG: begin
        hsrc    = HS_PCH;
        use_idx = 1'b0;
        mem_op  = 1'b0;
      end
      OP_JLONG: begin
        hsrc     = HS_PAIR;
        use_idx  = 1'b0;
        mem_op   = 1'b0;
        pch_load = 1'b1;
        wide_op  = 1'b1;
      end
      OP_LRREL: hsrc = HS_PCH;
      default: ;
    endcase
    priv_fault = wide_op & user & ~wide_ok;
  end
endmodule

// File: rtl/qagu_hisel.sv
module qagu_hisel
  import qagu_pkg::*;
#(
  parameter int HI_W   = 48,
  parameter int BASE_W = 64
) (
  input  hsrc_e             hsrc,
  input  logic [HI_W-1:0]   gbh,
  input  logic [HI_W-1:0]   pch,
  input  logic [BASE_W-1:0] pair_hi,
  output logic [HI_W-1:0]   hi
);
  always_comb begin
    case (hsrc)
      HS_PCH:  hi = pch;
      HS_PAIR: hi = pair_hi[HI_W-1:0];
      default: hi = gbh;
    endcase
  end
endmodule

// File: rtl/qagu_addgen.sv
module qagu_addgen #(
  parameter int HI_W   = 48,
  parameter int LO_W   = 48,
  parameter int BASE_W = 64,
  parameter int IDX_W  = 34,
  parameter int SC_W   = 2,
  localparam int AW    = HI_W + LO_W
) (
  input  logic [HI_W-1:0]   hi,
  input  logic [BASE_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  input  logic [SC_W-1:0]   scale,
  input  logic              use_idx,
  input  logic              lin,
  output logic [AW-1:0]     addr
);
  logic [AW-1:0]   idx_ext;
  logic [AW-1:0]   idx_sc;
  logic [AW-1:0]   base_ext;
  logic [LO_W-1:0] near_lo;
  logic [AW-1:0]   far_addr;

  assign idx_ext  = {{(AW-IDX_W){idx[IDX_W-1]}}, idx};
  assign idx_sc   = use_idx ? (idx_ext << scale) : '0;
  assign base_ext = {{(AW-BASE_W){1'b0}}, base};
  // Concatenated mode: carry out of the low half is dropped.
  assign near_lo  = base[LO_W-1:0] + idx_sc[LO_W-1:0];
  // Linear mode: quadrant is an additive term, carry may cross quadrants.
  assign far_addr = {hi, {LO_W{1'b0}}} + base_ext + idx_sc;
  assign addr     = lin ? far_addr : {hi, near_lo};
endmodule

// File: rtl/qagu_top.sv
module qagu_top
  import qagu_pkg::*;
#(
  parameter int HI_W   = 48,
  parameter int LO_W   = 48,
  parameter int BASE_W = 64,
  parameter int IDX_W  = 34,
  parameter int SC_W   = 2,
  localparam int AW    = HI_W + LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        in_op,
  input  logic              in_lin,
  input  logic              in_user,
  input  logic              in_wide_ok,
  input  logic [BASE_W-1:0] in_base,
  input  logic [BASE_W-1:0] in_pair_hi,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [SC_W-1:0]   in_scale,
  input  logic [HI_W-1:0]   in_gbh,
  input  logic [HI_W-1:0]   in_pch,
  output logic              out_valid,
  output logic [AW-1:0]     out_addr,
  output logic [1:0]        out_fault,
  output logic              out_pch_load
);
  agu_op_e       op_e;
  hsrc_e         hsrc;
  logic          use_idx, mem_op, pch_load, priv_fault;
  logic [HI_W-1:0] hi;
  logic [AW-1:0] addr_c;

  assign op_e = agu_op_e'(in_op);

  qagu_decode u_dec (
    .op(op_e), .user(in_user), .wide_ok(in_wide_ok), .hsrc(hsrc),
    .use_idx(use_idx), .mem_op(mem_op), .pch_load(pch_load), .priv_fault(priv_fault)
  );

  qagu_hisel #(.HI_W(HI_W), .BASE_W(BASE_W)) u_hi (
    .hsrc(hsrc), .gbh(in_gbh), .pch(in_pch), .pair_hi(in_pair_hi), .hi(hi)
  );

  qagu_addgen #(.HI_W(HI_W), .LO_W(LO_W), .BASE_W(BASE_W), .IDX_W(IDX_W), .SC_W(SC_W)) u_add (
    .hi(hi), .base(in_base), .idx(in_idx), .scale(in_scale),
    .use_idx(use_idx), .lin(in_lin & mem_op), .addr(addr_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_addr     <= '0;
      out_fault    <= FLT_NONE;
      out_pch_load <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        if (priv_fault) begin
          out_addr     <= '0;
          out_fault    <= FLT_PRIV;
          out_pch_load <= 1'b0;
        end else begin
          out_addr     <= addr_c;
          out_fault    <= FLT_NONE;
          out_pch_load <= pch_load;
        end
      end
    end
  end

  // R2: result valid one cycle after the request
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(out_addr) && $stable(out_fault));
  // R10: disallowed wide request yields a privilege fault and no address
  a_r10_priv_fault: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_user && !in_wide_ok && (op_e == OP_WIDE || op_e == OP_JLONG)
    |=> out_fault == 2'd1 && out_addr == '0 && !out_pch_load);
  // R5: register branch keeps PC-high quadrant and never loads PC-high
  a_r5_brreg_local: assert property (@(posedge clk) disable iff (rst)
    in_valid && op_e == OP_BRREG
    |=> out_addr == {$past(in_pch), $past(in_base[LO_W-1:0])} && !out_pch_load);
  // R6: a PC-high load only accompanies an unfaulted long jump
  a_r6_load_clean: assert property (@(posedge clk) disable iff (rst)
    out_pch_load |-> out_fault == 2'd0);
  // R3: plain access in concatenated mode takes the global high quadrant
  a_r3_gbh_quadrant: assert property (@(posedge clk) disable iff (rst)
    in_valid && op_e == OP_MEM && !in_lin
    |=> out_addr[AW-1:LO_W] == $past(in_gbh));
endmodule

// File: tb/tb_qagu_top.sv
module tb_qagu_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_lin, in_user, in_wide_ok;
  logic [2:0]  in_op;
  logic [63:0] in_base, in_pair_hi;
  logic [33:0] in_idx;
  logic [1:0]  in_scale;
  logic [47:0] in_gbh, in_pch;
  logic        out_valid, out_pch_load;
  logic [95:0] out_addr;
  logic [1:0]  out_fault;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  qagu_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_lin(in_lin),
    .in_user(in_user), .in_wide_ok(in_wide_ok), .in_base(in_base),
    .in_pair_hi(in_pair_hi), .in_idx(in_idx), .in_scale(in_scale),
    .in_gbh(in_gbh), .in_pch(in_pch), .out_valid(out_valid),
    .out_addr(out_addr), .out_fault(out_fault), .out_pch_load(out_pch_load)
  );

  function automatic bit exp_fault(logic [2:0] op, logic user, logic wok);
    return user && !wok && (op == 3'd1 || op == 3'd4);
  endfunction

  function automatic logic [95:0] exp_addr(logic [2:0] op, logic lin, logic user,
      logic wok, logic [63:0] base, logic [63:0] pair, logic [33:0] idx,
      logic [1:0] sc, logic [47:0] gbh, logic [47:0] pch);
    logic [47:0] hi;
    logic [95:0] s;
    bit memop;
    if (exp_fault(op, user, wok)) return '0;
    case (op)
      3'd1, 3'd4: hi = pair[47:0];
      3'd2, 3'd3, 3'd5: hi = pch;
      default: hi = gbh;
    endcase
    s = {{62{idx[33]}}, idx} << sc;
    memop = !(op == 3'd2 || op == 3'd3 || op == 3'd4);
    if (op == 3'd3 || op == 3'd4) return {hi, base[47:0]};
    if (lin && memop) return {hi, 48'd0} + {32'd0, base} + s;
    return {hi, base[47:0] + s[47:0]};
  endfunction

  function automatic string req_of(logic [2:0] op, logic lin, bit flt);
    if (flt) return "R10";
    if (lin && !(op == 3'd2 || op == 3'd3 || op == 3'd4)) return "R9";
    case (op)
      3'd1: return "R4";
      3'd2, 3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(string req, logic [95:0] act, logic [95:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic [2:0] op, logic lin, logic user, logic wok,
      logic [63:0] base, logic [63:0] pair, logic [33:0] idx, logic [1:0] sc,
      logic [47:0] gbh, logic [47:0] pch, string tag);
    bit f;
    string r;
    in_valid = 1'b1; in_op = op; in_lin = lin; in_user = user; in_wide_ok = wok;
    in_base = base; in_pair_hi = pair; in_idx = idx; in_scale = sc;
    in_gbh = gbh; in_pch = pch;
    @(negedge clk);
    f = exp_fault(op, user, wok);
    r = (tag == "") ? req_of(op, lin, f) : tag;
    chk({r, " addr"}, out_addr, exp_addr(op, lin, user, wok, base, pair, idx, sc, gbh, pch));
    chk({r, " fault"}, {94'd0, out_fault}, {95'd0, f});
    chk({r, " pch_load"}, {95'd0, out_pch_load}, {95'd0, (op == 3'd4 && !f)});
    chk("R2 valid", {95'd0, out_valid}, 96'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [95:0] held;
    void'($urandom(32'd20211026));
    rst = 1'b1; in_valid = 1'b0; in_op = '0; in_lin = 0; in_user = 0; in_wide_ok = 0;
    in_base = '0; in_pair_hi = '0; in_idx = '0; in_scale = '0; in_gbh = '0; in_pch = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", {95'd0, out_valid}, 96'd0);
    chk("R1 addr", out_addr, 96'd0);
    chk("R1 fault", {94'd0, out_fault}, 96'd0);
    chk("R1 pch_load", {95'd0, out_pch_load}, 96'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {95'd0, out_valid}, 96'd0);

    // Directed: each quadrant source
    run(3'd0, 0, 0, 0, 64'h0000_1234_5678_9ABC, 64'hFFFF, 34'd16, 2'd0, 48'hAAAA_0000_0001, 48'h5555, "R3");
    run(3'd1, 0, 1, 1, 64'h10, 64'hDEAD_BEEF_0000_7777, 34'd1, 2'd3, 48'h1, 48'h2, "R4");
    run(3'd2, 1, 0, 0, 64'hFFFF_0000_0000_0100, 64'h0, 34'h3_FFFF_FFFF, 2'd2, 48'h9, 48'h0000_CAFE_0000, "R5");
    run(3'd3, 1, 0, 0, 64'hFFFF_1111_2222_3333, 64'h0, 34'd99, 2'd1, 48'h9, 48'h00BB_0000_0001, "R5");
    run(3'd4, 1, 0, 0, 64'h0000_4444_5555_6666, 64'h1234_0000_00FF_0001, 34'd7, 2'd2, 48'h9, 48'h3, "R6");
    run(3'd5, 0, 0, 0, 64'h800, 64'h0, 34'h3_FFFF_FFF8, 2'd0, 48'h1, 48'h0000_7000_0000, "R7");
    // R8: negative index at every scale
    for (int s = 0; s < 4; s++)
      run(3'd0, 0, 0, 0, 64'h0000_0000_0001_0000, 64'h0, 34'h2_0000_0000, 2'(s), 48'h42, 48'h0, "R8");
    // R3: low-half carry dropped in concatenated mode
    run(3'd0, 0, 0, 0, 64'h0000_FFFF_FFFF_FFFF, 64'h0, 34'd1, 2'd0, 48'h7, 48'h0, "R3");
    // R9: carry crosses into quadrant, and full 96-bit wrap
    run(3'd0, 1, 0, 0, 64'h0000_FFFF_FFFF_FFFF, 64'h0, 34'd1, 2'd0, 48'h7, 48'h0, "R9");
    run(3'd1, 1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_FFFF_FFFF_FFFF, 34'd8, 2'd3, 48'h0, 48'h0, "R9");
    run(3'd5, 1, 0, 0, 64'h0, 64'h0, 34'h3_FFFF_FFFF, 2'd0, 48'h0, 48'h0, "R9");
    // R10: every permission combination for both wide codes
    for (int k = 0; k < 8; k++)
      run((k[2] ? 3'd4 : 3'd1), 0, k[1], k[0], 64'h1111_2222_3333_4444,
          64'h0000_9999_8888_7777, 34'd5, 2'd1, 48'h6, 48'h5, "R10");
    // R2: idle cycle holds outputs
    run(3'd0, 0, 0, 0, 64'hABCD, 64'h0, 34'd0, 2'd0, 48'h77, 48'h0, "R3");
    held = out_addr;
    in_valid = 1'b0; in_base = 64'h1; in_gbh = 48'h1; in_op = 3'd1;
    @(negedge clk);
    chk("R2 idle valid", {95'd0, out_valid}, 96'd0);
    chk("R2 idle addr", out_addr, held);
    chk("R2 idle fault", {94'd0, out_fault}, 96'd0);
    // Random mix
    for (int i = 0; i < 600; i++) begin
      run(3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          {$urandom, $urandom}, {$urandom, $urandom}, {2'($urandom), $urandom},
          2'($urandom), {16'($urandom), $urandom}, {16'($urandom), $urandom}, "");
      if (($urandom % 5) == 0) begin
        held = out_addr;
        in_valid = 1'b0;
        @(negedge clk);
        chk("R2 gap valid", {95'd0, out_valid}, 96'd0);
        chk("R2 gap addr", out_addr, held);
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule